// File: doc/BRIEF.md
# Vectored System Interrupt Controller

This block gathers sixteen interrupt sources and offers the most urgent one to a processor. Even source numbers come from eight active-low external pins. Odd source numbers come from eight active-high internal level lines. Each external pin passes through a two-stage synchroniser. Software chooses, pin by pin, whether that pin is treated as a level or as a latched falling edge.

A pending register, an enable (mask) register and an edge-select register are 32 bits wide. Source n sits at bit 31-n in each of them, so source 0 is the most significant bit. A read-only vector register carries the number of the winning source in bits 31:26. A single request line is high while any enabled source is pending.

Software reaches the registers over a plain synchronous bus with separate read and write strobes. The bus is a control path, not a data stream, so it has no valid/ready handshake and never stalls. A write takes effect at the clock edge where the write strobe is sampled. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `sirq_vector_ctrl`

## Requirements
- R1: Source n occupies bit 31-n of the pending (address 0), enable (address 1) and edge-select (address 2) registers. Bits 15:0 of these registers always read 0.
- R2: The vector register (address 3) holds, in bits 31:26, the lowest-numbered source that is both pending and enabled. Bits 25:0 read 0.
- R3: An even source n follows external pin n/2, which is active low, through two synchroniser flops. An odd source n is pending while internal line (n-1)/2 is high.
- R4: With its edge-select bit at 1, an external source becomes pending on a falling edge of its pin and stays pending until software writes 1 to its pending bit. Writing 0 to that bit leaves it set.
- R5: With its edge-select bit at 0, an external source's pending bit follows the inverted synchronised pin. Writing 1 to that pending bit has no effect.
- R6: Writing zero to the enable register disables every source: the request goes low and the vector reads idle even while sources are pending. Setting a bit enables that source.
- R7: The request output `irq_req` is high exactly when some source is pending and enabled.
- R8: With no source both pending and enabled, the vector register reads 0xFC000000 (all ones in bits 31:26).
- R9: After reset the enable and edge-select registers read 0 and no edge latch is set.
- R10: Edge-select bits of odd (internal) sources cannot be written and read 0.
- R11: Read data on `bus_rdata` is valid in the cycle after `bus_rd` is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 8 | External interrupt pins, active low; pin k feeds source 2k |
| int_lvl | input | 8 | Internal interrupt levels, active high; line k feeds source 2k+1 |
| bus_addr | input | 2 | Register select: 0 pending, 1 enable, 2 edge-select, 3 vector |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is an edge latch that must outlive the pin pulse that set it, and must survive a write of 0 before a write of 1 clears it. The bench enables edge mode first. It then drives a short low pulse on the pin and returns the pin high. It then reads pending, writes 0, reads again, writes 1 and reads once more. Priority is checked by holding an internal source and an external level source pending together, then removing the lower number through the enable register.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1,
    REG_EDGE = 2'd2,
    REG_VEC  = 2'd3
  } sirq_reg_e;

  localparam int VEC_W = 6;
  localparam logic [VEC_W-1:0] VEC_IDLE = '1;
endpackage

// File: rtl/sirq_pin_front.sv
module sirq_pin_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lat_q;
  logic                   pin_s;
  logic                   fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b1;
    else        sync_q[0] <= pin_n;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];
  assign fall  = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (!edge_mode)  lat_q <= 1'b0;
      else if (fall)   lat_q <= 1'b1;
      else if (clr)    lat_q <= 1'b0;
    end
  end

  assign pend = edge_mode ? lat_q : ~pin_s;

  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && edge_mode && !clr) |=> lat_q); // R4
  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> (!lat_q || edge_mode)); // R5
endmodule

// File: rtl/sirq_prio_pick.sv
module sirq_prio_pick #(
  parameter int N     = 16,
  parameter int VEC_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [VEC_W-1:0] code
);
  always_comb begin
    any  = 1'b0;
    code = '1;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        any  = 1'b1;
        code = VEC_W'(i);
      end
    end
  end

  always_comb begin
    if (!any) AST_IDLE_CODE: assert (code == '1); // R8
  end
endmodule

// File: rtl/sirq_vector_ctrl.sv
module sirq_vector_ctrl
  import sirq_pkg::*;
#(
  parameter int NUM_EXT     = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic [NUM_EXT-1:0] int_lvl,
  input  logic [1:0]         bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_req
);
  localparam int NUM_SRC = 2 * NUM_EXT;
  localparam int IDX_W   = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend_src;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] edge_q;
  logic [NUM_SRC-1:0] wsrc;
  logic [NUM_SRC-1:0] active;
  logic [VEC_W-1:0]   vec_code;
  logic               any_act;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;
  logic               wr_pend, wr_mask, wr_edge;

  assign wr_pend = bus_wr && (bus_addr == REG_PEND);
  assign wr_mask = bus_wr && (bus_addr == REG_MASK);
  assign wr_edge = bus_wr && (bus_addr == REG_EDGE);

  generate
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      assign wsrc[n] = bus_wdata[DATA_W-1-n];
      if (n % 2 == 0) begin : g_ext
        sirq_pin_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
          .clk       (clk),
          .rst_n     (rst_n),
          .pin_n     (ext_irq_n[n/2]),
          .edge_mode (edge_q[n]),
          .clr       (wr_pend && wsrc[n]),
          .pend      (pend_src[n])
        );
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)       edge_q[n] <= 1'b0;
          else if (wr_edge) edge_q[n] <= wsrc[n];
        end
      end else begin : g_int
        assign pend_src[n] = int_lvl[(n-1)/2];
        assign edge_q[n]   = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wsrc;
  end

  assign active = pend_src & mask_q;

  sirq_prio_pick #(.N(NUM_SRC), .VEC_W(VEC_W)) u_pick (
    .req  (active),
    .any  (any_act),
    .code (vec_code)
  );

  assign irq_req = any_act;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      REG_PEND: for (int n = 0; n < NUM_SRC; n++) rd_mux[DATA_W-1-n] = pend_src[n];
      REG_MASK: for (int n = 0; n < NUM_SRC; n++) rd_mux[DATA_W-1-n] = mask_q[n];
      REG_EDGE: for (int n = 0; n < NUM_SRC; n++) rd_mux[DATA_W-1-n] = edge_q[n];
      REG_VEC:  rd_mux[DATA_W-1 -: VEC_W] = vec_code;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> mask_q[vec_code[IDX_W-1:0]]); // R7
  AST_WINNER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (vec_code < VEC_W'(NUM_SRC))); // R2
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && (wsrc == '0)) |=> !irq_req); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

// File: tb/tb_sirq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_sirq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_irq_n = 8'hFF;
  logic [7:0]  int_lvl = 8'h00;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  sirq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_lvl(int_lvl),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  function automatic logic [31:0] sbit(input int n);
    return 32'h8000_0000 >> n;
  endfunction

  function automatic logic [31:0] vec_of(input int n);
    return {n[5:0], 26'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(2'd1, d); check("R9 mask reset", d, 32'h0);
    reg_rd(2'd2, d); check("R9 edge reset", d, 32'h0);
    reg_rd(2'd0, d); check("R9 pending reset", d, 32'h0);
    reg_rd(2'd3, d); check("R8 idle vector", d, 32'hFC00_0000);
    check("R7 irq idle", {31'h0, irq_req}, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] d, d2;
    reg_wr(2'd1, 32'hFFFF_FFFF);
    reg_rd(2'd1, d); check("R1 mask layout", d, 32'hFFFF_0000);
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_rd(2'd2, d); check("R10 odd edge bits", d, 32'hAAAA_0000);
    reg_wr(2'd2, 32'h0);
    reg_wr(2'd1, 32'h0);
    reg_rd(2'd1, d);
    @(negedge clk); @(negedge clk);
    d2 = bus_rdata;
    check("R11 rdata holds", d2, d);
  endtask

  task automatic t_internal();
    logic [31:0] d;
    @(negedge clk); int_lvl[2] = 1'b1;
    settle();
    reg_rd(2'd0, d); check("R3 internal pending", d, sbit(5));
    check("R6 masked irq", {31'h0, irq_req}, 32'h0);
    reg_rd(2'd3, d); check("R6 masked vector idle", d, 32'hFC00_0000);
    reg_wr(2'd1, sbit(5));
    @(negedge clk);
    check("R7 irq on", {31'h0, irq_req}, 32'h1);
    reg_rd(2'd3, d); check("R2 vector 5", d, vec_of(5));
  endtask

  task automatic t_level_prio();
    logic [31:0] d;
    @(negedge clk); ext_irq_n[3] = 1'b0;
    settle();
    reg_rd(2'd0, d); check("R3 level pending", d, sbit(5) | sbit(6));
    reg_wr(2'd1, sbit(5) | sbit(6));
    reg_rd(2'd3, d); check("R2 lower number wins", d, vec_of(5));
    reg_wr(2'd0, sbit(6));
    reg_rd(2'd0, d); check("R5 w1c ignored in level", d, sbit(5) | sbit(6));
    reg_wr(2'd1, sbit(6));
    reg_rd(2'd3, d); check("R2 vector 6", d, vec_of(6));
    @(negedge clk); ext_irq_n[3] = 1'b1;
    settle();
    reg_rd(2'd0, d); check("R5 level release", d, sbit(5));
    check("R7 irq off", {31'h0, irq_req}, 32'h0);
    @(negedge clk); ext_irq_n[0] = 1'b0;
    settle();
    reg_wr(2'd1, sbit(0) | sbit(5));
    reg_rd(2'd3, d); check("R2 source 0 wins", d, vec_of(0));
    reg_wr(2'd1, 32'h0);
    @(negedge clk);
    check("R6 all disabled irq", {31'h0, irq_req}, 32'h0);
    reg_rd(2'd3, d); check("R6 all disabled vector", d, 32'hFC00_0000);
    @(negedge clk); ext_irq_n[0] = 1'b1; int_lvl[2] = 1'b0;
    settle();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    reg_wr(2'd2, sbit(2));
    reg_wr(2'd1, sbit(2));
    @(negedge clk); ext_irq_n[1] = 1'b0;
    repeat (3) @(negedge clk);
    ext_irq_n[1] = 1'b1;
    settle();
    reg_rd(2'd0, d); check("R4 edge latched", d, sbit(2));
    check("R7 irq from edge", {31'h0, irq_req}, 32'h1);
    reg_rd(2'd3, d); check("R2 vector 2", d, vec_of(2));
    reg_wr(2'd0, 32'h0);
    reg_rd(2'd0, d); check("R4 write 0 keeps", d, sbit(2));
    reg_wr(2'd0, sbit(2));
    reg_rd(2'd0, d); check("R4 write 1 clears", d, 32'h0);
    check("R7 irq cleared", {31'h0, irq_req}, 32'h0);
    reg_wr(2'd2, 32'h0);
    reg_wr(2'd1, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_layout();
    t_internal();
    t_level_prio();
    t_edge();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule